// File: doc/BRIEF.md
# DMA Peripheral Request Handshake

This block sits between one peripheral's DMA request lines and a single channel engine of a DMA controller. The peripheral raises one of four request lines and holds it high. The four lines are single, burst, last single and last burst. The block samples the lines on the rising clock edge. It can optionally pass each line through a two-flop synchroniser when the peripheral runs on its own clock. It then presents one pending request, with its kind, to the channel engine.

The engine moves the data and pulses a completion strobe when the final item of that transfer is done. It also flags whether the packet ends there. The block then raises a clear acknowledge toward the peripheral, together with terminal count when the packet ended. Clear stays high until the peripheral withdraws its request. While clear is high, no new request is reported. This stops one held request from being counted twice. Reset is synchronous and active high.

Top module: `dma_req_handshake`

## Requirements
- R1: While reset is high and after it is released, with no request active, `clr_out`, `tc_out` and `pend_valid` are 0 and `pend_kind` is 0.
- R2: With `sync_en` = 0, `pend_valid` rises at the second rising edge after the first edge that samples a request line high: one input register plus the state machine.
- R3: With `sync_en` = 1, `pend_valid` rises at the third rising edge after the first edge that samples a request line high, because of the two-flop synchroniser.
- R4: `req_in` bit 0 is single, bit 1 is burst, bit 2 is last single and bit 3 is last burst. While pending, `pend_kind` is 4 when bit 3 is set. Otherwise it is 3 when bit 2 is set, 2 when bit 1 is set, and 1 when only bit 0 is set. A last request wins over a non-last one, and burst wins over single.
- R5: `clr_out` stays 0 while a request is pending and `xfer_done` is low. It rises at the edge that samples `xfer_done` high while `pend_valid` is 1.
- R6: `tc_out` rises together with `clr_out` exactly when `xfer_eop` is high with that `xfer_done`. It stays 0 otherwise, and it falls together with `clr_out`.
- R7: `clr_out` stays high while the request is held. With `sync_en` = 0 it falls at the second edge after the first edge that samples all request lines low. With `sync_en` = 1 it falls at the third such edge.
- R8: While `clr_out` is high, `pend_valid` stays 0 even though the request is still held. After clear falls, a fresh request is reported again.
- R9: A `xfer_done` pulse while idle or while clear is high has no effect: `clr_out` and `tc_out` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_en | input | 1 | 1 routes the request lines through the two-flop synchroniser |
| req_in | input | 4 | Peripheral request lines {last burst, last single, burst, single} |
| xfer_done | input | 1 | Engine strobe: the final data item of the pending transfer has moved |
| xfer_eop | input | 1 | Engine flag, valid with `xfer_done`: the packet ends here |
| pend_valid | output | 1 | A request is pending for the engine |
| pend_kind | output | 3 | Kind of the pending request (encoding in R4), 0 when none is pending |
| clr_out | output | 1 | Clear acknowledge to the peripheral |
| tc_out | output | 1 | Terminal count to the peripheral |

## Verification
A wrong handshake state shows at the ports within one or two clock edges. A stuck pending state leaves `clr_out` low after `xfer_done`. A state that skips the clear phase makes `pend_valid` rise again while the request is still held. A wrong latched kind shows directly on `pend_kind`. A fault in a synchroniser path shifts the edge at which `pend_valid` rises or `clr_out` falls by one cycle. The bench sweeps every non-zero request pattern under both synchroniser settings, with and without end of packet, and counts those edges exactly.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;

    localparam int unsigned NUM_LINES = 4;
    localparam int unsigned KIND_W    = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_NONE    = 3'd0,
        KIND_SINGLE  = 3'd1,
        KIND_BURST   = 3'd2,
        KIND_LSINGLE = 3'd3,
        KIND_LBURST  = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_PEND  = 2'd1,
        HS_CLEAR = 2'd2
    } hs_state_e;

    typedef struct packed {
        hs_state_e state;
        req_kind_e kind;
        logic      tc;
    } hs_reg_t;

    // Last beats non-last, burst beats single.
    function automatic req_kind_e pick_kind(input logic [NUM_LINES-1:0] lines);
        if (lines[3])      return KIND_LBURST;
        else if (lines[2]) return KIND_LSINGLE;
        else if (lines[1]) return KIND_BURST;
        else if (lines[0]) return KIND_SINGLE;
        else               return KIND_NONE;
    endfunction

endpackage

// File: rtl/dmahs_line_sync.sv
module dmahs_line_sync (
    input  logic clk,
    input  logic rst,
    input  logic sync_en,
    input  logic line_in,
    output logic line_out
);

    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= line_in;
            stage2_q <= stage1_q;
        end
    end

    assign line_out = sync_en ? stage2_q : stage1_q;

    // Bypass path registers the line exactly once.
    assert_bypass_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (!sync_en && !$past(rst)) |-> (line_out == $past(line_in)));

endmodule

// File: rtl/dmahs_fsm.sv
module dmahs_fsm
    import dmahs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] req_s,
    input  logic                 done,
    input  logic                 eop,
    output logic                 pend_valid,
    output req_kind_e            pend_kind,
    output logic                 clr,
    output logic                 tc
);

    hs_reg_t cur_q;
    hs_reg_t nxt;
    logic    any_req;

    assign any_req = |req_s;

    always_comb begin
        nxt = cur_q;
        unique case (cur_q.state)
            HS_IDLE: begin
                if (any_req) begin
                    nxt.state = HS_PEND;
                    nxt.kind  = pick_kind(req_s);
                end
            end
            HS_PEND: begin
                if (done) begin
                    nxt.state = HS_CLEAR;
                    nxt.tc    = eop;
                end
            end
            HS_CLEAR: begin
                if (!any_req) begin
                    nxt.state = HS_IDLE;
                    nxt.tc    = 1'b0;
                    nxt.kind  = KIND_NONE;
                end
            end
            default: nxt = '{state: HS_IDLE, kind: KIND_NONE, tc: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '{state: HS_IDLE, kind: KIND_NONE, tc: 1'b0};
        else     cur_q <= nxt;
    end

    assign pend_valid = (cur_q.state == HS_PEND);
    assign pend_kind  = pend_valid ? cur_q.kind : KIND_NONE;
    assign clr        = (cur_q.state == HS_CLEAR);
    assign tc         = cur_q.tc;

    assert_kind_known_R4: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> (pend_kind != KIND_NONE));

    assert_clr_after_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(clr) |-> ($past(done) && $past(pend_valid)));

    assert_tc_with_clr_R6: assert property (@(posedge clk) disable iff (rst)
        tc |-> clr);

    assert_clr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && any_req) |=> clr);

    assert_no_pend_in_clr_R8: assert property (@(posedge clk) disable iff (rst)
        clr |-> !pend_valid);

    assert_done_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!pend_valid && !clr) |=> !clr);

endmodule

// File: rtl/dma_req_handshake.sv
module dma_req_handshake
    import dmahs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sync_en,
    input  logic [NUM_LINES-1:0] req_in,
    input  logic                 xfer_done,
    input  logic                 xfer_eop,
    output logic                 pend_valid,
    output logic [KIND_W-1:0]    pend_kind,
    output logic                 clr_out,
    output logic                 tc_out
);

    logic [NUM_LINES-1:0] req_s;
    req_kind_e            kind_w;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        dmahs_line_sync u_sync (
            .clk      (clk),
            .rst      (rst),
            .sync_en  (sync_en),
            .line_in  (req_in[g]),
            .line_out (req_s[g])
        );
    end

    dmahs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_s      (req_s),
        .done       (xfer_done),
        .eop        (xfer_eop),
        .pend_valid (pend_valid),
        .pend_kind  (kind_w),
        .clr        (clr_out),
        .tc         (tc_out)
    );

    assign pend_kind = kind_w;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!clr_out && !tc_out && !pend_valid));

endmodule

// File: tb/test_dma_req_handshake.sv
module test_dma_req_handshake;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_en = 1'b0;
    logic [3:0] req_in = 4'd0;
    logic       xfer_done = 1'b0;
    logic       xfer_eop = 1'b0;
    logic       pend_valid;
    logic [2:0] pend_kind;
    logic       clr_out;
    logic       tc_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_run = 1'b0;

    always #4 clk = ~clk;

    dma_req_handshake i_dma_req_handshake (
        .clk(clk), .rst(rst), .sync_en(sync_en), .req_in(req_in),
        .xfer_done(xfer_done), .xfer_eop(xfer_eop),
        .pend_valid(pend_valid), .pend_kind(pend_kind),
        .clr_out(clr_out), .tc_out(tc_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_kind(input logic [3:0] p);
        if (p[3]) return 4;
        if (p[2]) return 3;
        if (p[1]) return 2;
        return 1;
    endfunction

    task automatic one_case(input logic [3:0] pat, input bit sen, input bit eop);
        int n;
        int lat;
        lat = sen ? 3 : 2;
        @(negedge clk);
        sync_en = sen;
        req_in  = pat;
        n = 0;
        while (!pend_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(sen ? "R3 pend latency sync" : "R2 pend latency bypass", n, lat);
        check("R4 kind", pend_kind, exp_kind(pat));
        repeat (2) @(negedge clk);
        check("R5 no clear before done", clr_out, 0);
        check("R5 still pending", pend_valid, 1);
        xfer_done = 1'b1;
        xfer_eop  = eop;
        @(negedge clk);
        xfer_done = 1'b0;
        xfer_eop  = 1'b0;
        check("R5 clear after done", clr_out, 1);
        check("R6 tc with clear", tc_out, eop);
        // done strobe during clear must be ignored
        xfer_done = 1'b1;
        xfer_eop  = ~eop;
        @(negedge clk);
        xfer_done = 1'b0;
        xfer_eop  = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 clear held", clr_out, 1);
        check("R9 tc unchanged by done in clear", tc_out, eop);
        check("R8 no repeat pend", pend_valid, 0);
        req_in = 4'd0;
        n = 0;
        while (clr_out && n < 10) begin
            @(negedge clk);
            n++;
            if (clr_out) check("R6 tc holds with clear", tc_out, eop);
        end
        check("R7 clear release latency", n, lat);
        check("R6 tc falls with clear", tc_out, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 clr in reset", clr_out, 0);
        check("R1 pend in reset", pend_valid, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 clr after reset", clr_out, 0);
        check("R1 tc after reset", tc_out, 0);
        check("R1 pend after reset", pend_valid, 0);
        check("R1 kind after reset", pend_kind, 0);
        // done while idle
        xfer_done = 1'b1;
        xfer_eop  = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        xfer_eop  = 1'b0;
        @(negedge clk);
        check("R9 idle done clr", clr_out, 0);
        check("R9 idle done tc", tc_out, 0);
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 2; e++)
                for (int p = 1; p < 16; p++)
                    one_case(4'(p), s[0], e[0]);
        // back-to-back re-request after clear (R8)
        one_case(4'b0001, 1'b0, 1'b0);
        one_case(4'b0001, 1'b0, 1'b1);
        done_run = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done_run && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done_run) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule